// File: doc/BRIEF.md
# NAND Page ECC Register Front-End

This block is the software-visible face of a Reed-Solomon page codec used on a NAND flash path. Software programs it through a small 32-bit register bus with per-byte write enables. It holds the control word, a bank of parity bytes, the status and interrupt-enable words, and a set of error-report words. It also drives a start/abort/clear handshake toward a codec whose arithmetic lies outside this block.

In encode mode the block starts the codec as soon as it is enabled. When the codec reports completion, the block captures the computed parity. In decode mode it holds the codec back until software has loaded the stored parity and raised a parity-ready bit. When the decode completes, it records whether errors were found, how many, and whether they can be corrected, and it fills one report word per located error. An interrupt line combines the status flags that software has unmasked.

Top module: `ecc_ctrl_front`

## Requirements
- R1: The register map is decoded from `bus_addr[7:2]` as word offsets. 0x00 is control, 0x04 is the data port, 0x08/0x0C/0x10 are the parity words, 0x14 is status, 0x18 is interrupt enable, and report word i sits at 0x1C+4*i. Reads of any other word, and of the data port, return zero.
- R2: Control bits are enable (bit 0), reset (bit 1), RS mode (bit 2, driven on `cdc_rs`), encode-not-decode (bit 3) and parity-ready (bit 4). A control write takes effect only when byte lane 0 is enabled.
- R3: A set reset bit raises `cdc_clear` for exactly one cycle. That cycle clears the parity bank, the report words, the sequencer and the parity-ready bit. The reset bit then reads back as 0.
- R4: When enabled with encode selected, the block pulses `cdc_start` with `cdc_encode`=1 in the cycle after reset clears. A later `cdc_enc_done` loads `cdc_enc_par` into the parity bank and sets status bit 2.
- R5: Parity byte k lives in word 0x08+4*(k/4), byte lane k%4, and on `cdc_par_in[8k+7:8k]`. Each byte is written only when its own lane enable is set. Lanes beyond byte 8 read as zero.
- R6: In decode mode `cdc_start` stays low until parity-ready is set. It then pulses with `cdc_encode`=0 and the loaded parity on `cdc_par_in`. A later `cdc_dec_done` sets status bit 3.
- R7: After a correctable decode, status bits 31:29 hold the error count and bit 0 is set exactly when the count is non-zero. Report word i holds the location index plus one in bits 24:16 and the 9-bit mask in bits 8:0 for i below the count, and reads zero otherwise.
- R8: After an uncorrectable decode, status bits 1 and 0 are set, the count field reads zero, and the report words are left untouched.
- R9: A status write of all-zero data clears every flag and the count. A status write of non-zero data has no effect.
- R10: Clearing enable while an operation is pending pulses `cdc_abort` once and returns to idle. Status is unchanged, and a codec completion arriving afterwards is ignored.
- R11: `irq` is the OR of status bits 4:0, each ANDed with the matching bit of the interrupt-enable word.
- R12: A full-word write to the data port pulses `cdc_dat_vld` with the word on `cdc_dat`. `cdc_pad_done` while enabled sets status bit 4.
- R13: Codec completion pulses that arrive outside their matching busy phase change neither status nor parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_be | input | 4 | Byte lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Masked status interrupt |
| cdc_start | output | 1 | Start pulse to the codec |
| cdc_encode | output | 1 | Operation kind for the codec, 1 = encode |
| cdc_rs | output | 1 | RS mode select |
| cdc_abort | output | 1 | Abort pulse to the codec |
| cdc_clear | output | 1 | Codec state clear pulse |
| cdc_par_in | output | 72 | Parity bank contents, byte k at bits 8k+7:8k |
| cdc_dat_vld | output | 1 | Data word valid |
| cdc_dat | output | 32 | Data word |
| cdc_enc_done | input | 1 | Encode completion pulse |
| cdc_enc_par | input | 72 | Parity computed by the codec |
| cdc_dec_done | input | 1 | Decode completion pulse |
| cdc_uncor | input | 1 | Decode found uncorrectable errors |
| cdc_err_cnt | input | 3 | Number of located errors |
| cdc_err_idx | input | 36 | Zero-based symbol index per error, 9 bits each |
| cdc_err_msk | input | 36 | Error mask per error, 9 bits each |
| cdc_pad_done | input | 1 | Padding completion pulse |

## Verification
Decode completions are swept over every error count from zero to the bank depth. One of these runs places the locations at index 0 and index 510, which separates a correct plus-one offset from an off-by-one or a wrap. An uncorrectable completion that still carries non-zero locations distinguishes a bank that gates its load from one that records stale data. Every parity byte is written with the same value replicated in all four lanes, so a wrong lane decode shows up as a misplaced byte. The interrupt enable word is swept through all 32 values against three different flag patterns, which isolates each mask bit.

// File: rtl/ecc_front_pkg.sv
package ecc_front_pkg;
   // word offsets (byte address >> 2)
   localparam int W_CTL  = 0;
   localparam int W_DATA = 1;
   localparam int W_PAR  = 2;
   localparam int W_STAT = 5;
   localparam int W_IEN  = 6;
   localparam int W_ERR  = 7;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_RST  = 1;
   localparam int CB_RS   = 2;
   localparam int CB_ENC  = 3;
   localparam int CB_PRDY = 4;
   localparam int CTL_W   = 5;

   // status bit positions
   localparam int SB_ERR = 0;
   localparam int SB_UNC = 1;
   localparam int SB_ENC = 2;
   localparam int SB_DEC = 3;
   localparam int SB_PAD = 4;
   localparam int FLAG_W = 5;

   localparam int LOC_LSB = 16;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_ENC, SQ_WAIT, SQ_DEC, SQ_DONE
   } seq_state_t;
endpackage

// File: rtl/ecc_par_bank.sv
module ecc_par_bank #(
   parameter int NBYTES = 9,
   parameter int IDX_W  = 6,
   parameter int BASE   = 2,
   localparam int PBITS = NBYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [3:0]       wr_be,
   input  logic [31:0]      wr_data,
   input  logic             ld,
   input  logic [PBITS-1:0] ld_par,
   output logic [PBITS-1:0] par
);
   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      localparam int LANE = k % 4;
      localparam int WORD = BASE + k / 4;
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(WORD)) && wr_be[LANE];
      always_ff @(posedge clk) begin
         if (!rst_n)   par[k*8 +: 8] <= '0;
         else if (clr) par[k*8 +: 8] <= '0;
         else if (ld)  par[k*8 +: 8] <= ld_par[k*8 +: 8];
         else if (hit) par[k*8 +: 8] <= wr_data[LANE*8 +: 8];
      end
   end
endmodule

// File: rtl/ecc_err_bank.sv
module ecc_err_bank #(
   parameter int NUM_ERR = 4,
   parameter int SYM_W   = 9,
   parameter int CNT_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     ld,
   input  logic [CNT_W-1:0]         cnt,
   input  logic [NUM_ERR*SYM_W-1:0] idx_in,
   input  logic [NUM_ERR*SYM_W-1:0] msk_in,
   output logic [NUM_ERR*SYM_W-1:0] loc_q,
   output logic [NUM_ERR*SYM_W-1:0] msk_q
);
   for (genvar i = 0; i < NUM_ERR; i++) begin : g_ent
      logic used;
      assign used = int'(cnt) > i;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            loc_q[i*SYM_W +: SYM_W] <= '0;
            msk_q[i*SYM_W +: SYM_W] <= '0;
         end else if (ld) begin
            loc_q[i*SYM_W +: SYM_W] <= used ? idx_in[i*SYM_W +: SYM_W] + SYM_W'(1) : '0;
            msk_q[i*SYM_W +: SYM_W] <= used ? msk_in[i*SYM_W +: SYM_W] : '0;
         end
      end
   end
endmodule

// File: rtl/ecc_seq_fsm.sv
module ecc_seq_fsm
   import ecc_front_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_en,
   input  logic ctl_rst,
   input  logic ctl_enc,
   input  logic ctl_prdy,
   input  logic enc_done,
   input  logic dec_done,
   output logic start,
   output logic abort,
   output logic enc_acc,
   output logic dec_acc
);
   seq_state_t st_q, st_d;
   logic live, busy;

   assign live    = ctl_en && !ctl_rst;
   assign busy    = (st_q == SQ_ENC) || (st_q == SQ_WAIT) || (st_q == SQ_DEC);
   assign start   = live && (((st_q == SQ_IDLE) && ctl_enc) || ((st_q == SQ_WAIT) && ctl_prdy));
   assign abort   = !ctl_rst && !ctl_en && busy;
   assign enc_acc = live && (st_q == SQ_ENC) && enc_done;
   assign dec_acc = live && (st_q == SQ_DEC) && dec_done;

   always_comb begin
      st_d = st_q;
      if (ctl_rst || !ctl_en) st_d = SQ_IDLE;
      else begin
         case (st_q)
            SQ_IDLE: st_d = ctl_enc ? SQ_ENC : SQ_WAIT;
            SQ_WAIT: if (ctl_prdy) st_d = SQ_DEC;
            SQ_ENC:  if (enc_done) st_d = SQ_DONE;
            SQ_DEC:  if (dec_done) st_d = SQ_DONE;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/ecc_stat_irq.sv
module ecc_stat_irq
   import ecc_front_pkg::*;
#(
   parameter int CNT_W   = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_wr,
   input  logic              enc_acc,
   input  logic              dec_acc,
   input  logic              uncor,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              pad_acc,
   input  logic [FLAG_W-1:0] ien,
   output logic [FLAG_W-1:0] flags,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              irq
);
   logic [FLAG_W-1:0] flags_d;
   logic [CNT_W-1:0]  cnt_d;

   always_comb begin
      flags_d = clr_wr ? '0 : flags;
      cnt_d   = clr_wr ? '0 : cnt_q;
      if (enc_acc) flags_d[SB_ENC] = 1'b1;
      if (dec_acc) begin
         flags_d[SB_DEC] = 1'b1;
         flags_d[SB_UNC] = uncor;
         flags_d[SB_ERR] = uncor || (cnt_in != '0);
         cnt_d           = uncor ? '0 : cnt_in;
      end
      if (pad_acc) flags_d[SB_PAD] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         cnt_q <= '0;
      end else begin
         flags <= flags_d;
         cnt_q <= cnt_d;
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(flags_d & ien);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(flags & ien);
   end
endmodule

// File: rtl/ecc_ctrl_front.sv
module ecc_ctrl_front
   import ecc_front_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NBYTES  = 9,
   parameter int NUM_ERR = 4,
   parameter int SYM_W   = 9,
   parameter int CNT_W   = 3,
   parameter bit IRQ_REG = 1'b0,
   localparam int PBITS  = NBYTES * 8,
   localparam int EBITS  = NUM_ERR * SYM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              cdc_start,
   output logic              cdc_encode,
   output logic              cdc_rs,
   output logic              cdc_abort,
   output logic              cdc_clear,
   output logic [PBITS-1:0]  cdc_par_in,
   output logic              cdc_dat_vld,
   output logic [31:0]       cdc_dat,
   input  logic              cdc_enc_done,
   input  logic [PBITS-1:0]  cdc_enc_par,
   input  logic              cdc_dec_done,
   input  logic              cdc_uncor,
   input  logic [CNT_W-1:0]  cdc_err_cnt,
   input  logic [EBITS-1:0]  cdc_err_idx,
   input  logic [EBITS-1:0]  cdc_err_msk,
   input  logic              cdc_pad_done
);
   localparam int IDX_W     = ADDR_W - 2;
   localparam int PAR_WORDS = (NBYTES + 3) / 4;

   if (PAR_WORDS > W_STAT - W_PAR) begin : g_bad_par
      $error("parity bank overlaps the status word");
   end
   if (NUM_ERR > (1 << CNT_W) - 1) begin : g_bad_cnt
      $error("error count field too narrow for report bank");
   end
   if (W_ERR + NUM_ERR > (1 << IDX_W)) begin : g_bad_addr
      $error("address width too small for report bank");
   end
   if (SYM_W > LOC_LSB || CNT_W > 27) begin : g_bad_fld
      $error("field widths do not fit the register layout");
   end

   logic [IDX_W-1:0]  widx;
   logic              wr, ctl_wr, ien_wr, stat_zero_wr, par_wr;
   logic [CTL_W-1:0]  ctl_q;
   logic [FLAG_W-1:0] ien_q;
   logic [FLAG_W-1:0] stat_flags;
   logic [CNT_W-1:0]  stat_cnt;
   logic              enc_acc, dec_acc;
   logic [EBITS-1:0]  err_loc, err_msk;
   logic              addr_lsb_unused;

   assign addr_lsb_unused = ^bus_addr[1:0];
   assign widx         = bus_addr[ADDR_W-1:2];
   assign wr           = bus_en && bus_we;
   assign ctl_wr       = wr && (widx == IDX_W'(W_CTL)) && bus_be[0];
   assign ien_wr       = wr && (widx == IDX_W'(W_IEN)) && bus_be[0];
   assign stat_zero_wr = wr && (widx == IDX_W'(W_STAT)) && (|bus_be) && (bus_wdata == '0);
   assign par_wr       = wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q <= bus_wdata[CTL_W-1:0];
      end else if (ctl_q[CB_RST]) begin
         ctl_q[CB_RST]  <= 1'b0;
         ctl_q[CB_PRDY] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_wr) ien_q <= bus_wdata[FLAG_W-1:0];
   end

   assign cdc_clear   = ctl_q[CB_RST];
   assign cdc_encode  = ctl_q[CB_ENC];
   assign cdc_rs      = ctl_q[CB_RS];
   assign cdc_dat_vld = wr && (widx == IDX_W'(W_DATA)) && (bus_be == 4'hF);
   assign cdc_dat     = bus_wdata;

   ecc_seq_fsm u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_en   (ctl_q[CB_EN]),
      .ctl_rst  (ctl_q[CB_RST]),
      .ctl_enc  (ctl_q[CB_ENC]),
      .ctl_prdy (ctl_q[CB_PRDY]),
      .enc_done (cdc_enc_done),
      .dec_done (cdc_dec_done),
      .start    (cdc_start),
      .abort    (cdc_abort),
      .enc_acc  (enc_acc),
      .dec_acc  (dec_acc)
   );

   ecc_par_bank #(.NBYTES(NBYTES), .IDX_W(IDX_W), .BASE(W_PAR)) u_par (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctl_q[CB_RST]),
      .wr_en   (par_wr),
      .wr_idx  (widx),
      .wr_be   (bus_be),
      .wr_data (bus_wdata),
      .ld      (enc_acc),
      .ld_par  (cdc_enc_par),
      .par     (cdc_par_in)
   );

   ecc_err_bank #(.NUM_ERR(NUM_ERR), .SYM_W(SYM_W), .CNT_W(CNT_W)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctl_q[CB_RST]),
      .ld     (dec_acc && !cdc_uncor),
      .cnt    (cdc_err_cnt),
      .idx_in (cdc_err_idx),
      .msk_in (cdc_err_msk),
      .loc_q  (err_loc),
      .msk_q  (err_msk)
   );

   ecc_stat_irq #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_wr  (stat_zero_wr),
      .enc_acc (enc_acc),
      .dec_acc (dec_acc),
      .uncor   (cdc_uncor),
      .cnt_in  (cdc_err_cnt),
      .pad_acc (cdc_pad_done && ctl_q[CB_EN]),
      .ien     (ien_q),
      .flags   (stat_flags),
      .cnt_q   (stat_cnt),
      .irq     (irq)
   );

   // read views
   logic [31:0] par_rd [PAR_WORDS];
   logic [31:0] err_rd [NUM_ERR];

   for (genvar w = 0; w < PAR_WORDS; w++) begin : g_pword
      for (genvar l = 0; l < 4; l++) begin : g_lane
         if (w * 4 + l < NBYTES) begin : g_live
            assign par_rd[w][l*8 +: 8] = cdc_par_in[(w*4+l)*8 +: 8];
         end else begin : g_pad
            assign par_rd[w][l*8 +: 8] = 8'h00;
         end
      end
   end

   for (genvar i = 0; i < NUM_ERR; i++) begin : g_eword
      assign err_rd[i] = (32'(err_loc[i*SYM_W +: SYM_W]) << LOC_LSB)
                       | 32'(err_msk[i*SYM_W +: SYM_W]);
   end

   always_comb begin
      bus_rdata = '0;
      if (widx == IDX_W'(W_CTL)) bus_rdata[CTL_W-1:0] = ctl_q;
      if (widx == IDX_W'(W_IEN)) bus_rdata[FLAG_W-1:0] = ien_q;
      if (widx == IDX_W'(W_STAT)) begin
         bus_rdata[FLAG_W-1:0] = stat_flags;
         bus_rdata[31 -: CNT_W] = stat_cnt;
      end
      for (int w = 0; w < PAR_WORDS; w++)
         if (widx == IDX_W'(W_PAR + w)) bus_rdata = par_rd[w];
      for (int i = 0; i < NUM_ERR; i++)
         if (widx == IDX_W'(W_ERR + i)) bus_rdata = err_rd[i];
   end
endmodule

// File: rtl/ecc_ctrl_front_chk.sv
module ecc_ctrl_front_chk #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [3:0]        bus_be,
   input logic [31:0]       bus_wdata,
   input logic              cdc_start,
   input logic              cdc_abort,
   input logic              cdc_clear,
   input logic              cdc_encode,
   input logic              cdc_enc_done,
   input logic              cdc_dec_done,
   input logic              cdc_pad_done,
   input logic [4:0]        ctl_q,
   input logic [4:0]        stat_flags,
   input logic [CNT_W-1:0]  stat_cnt
);
   logic ctl_hit, stat_hit, stat_zero;
   assign ctl_hit   = bus_en && bus_we && (bus_addr[ADDR_W-1:2] == '0) && bus_be[0];
   assign stat_hit  = bus_en && bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5)) && (|bus_be);
   assign stat_zero = stat_hit && (bus_wdata == '0);

   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_clear && !ctl_hit) |=> !cdc_clear); // R3
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cdc_start, cdc_abort, cdc_clear})); // R10
   AST_DEC_NEEDS_PRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_start && !cdc_encode) |-> ctl_q[4]); // R6
   AST_STAT_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_zero && !cdc_enc_done && !cdc_dec_done && !cdc_pad_done)
      |=> (stat_flags == '0 && stat_cnt == '0)); // R9
   AST_UNCOR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flags[1] |-> (stat_cnt == '0 && stat_flags[0])); // R8
   AST_ABORT_KEEPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_abort && !stat_hit && !cdc_pad_done) |=> $stable(stat_flags)); // R10
endmodule

bind ecc_ctrl_front ecc_ctrl_front_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/ecc_ctrl_front_tb_top.sv
`timescale 1ns/1ps
module ecc_ctrl_front_tb_top;
   localparam int NB = 9;
   localparam int NE = 4;
   localparam int SW = 9;
   localparam int CW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [3:0]        bus_be = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              irq, cdc_start, cdc_encode, cdc_rs, cdc_abort, cdc_clear;
   logic [NB*8-1:0]   cdc_par_in;
   logic              cdc_dat_vld;
   logic [31:0]       cdc_dat;
   logic              cdc_enc_done = 1'b0;
   logic [NB*8-1:0]   cdc_enc_par = '0;
   logic              cdc_dec_done = 1'b0, cdc_uncor = 1'b0;
   logic [CW-1:0]     cdc_err_cnt = '0;
   logic [NE*SW-1:0]  cdc_err_idx = '0, cdc_err_msk = '0;
   logic              cdc_pad_done = 1'b0;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   ecc_ctrl_front dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic chk_par(input string req, input logic [NB*8-1:0] p);
      for (int w = 0; w < 3; w++) begin
         logic [31:0] e;
         e = '0;
         for (int l = 0; l < 4; l++)
            if (w * 4 + l < NB) e[l*8 +: 8] = p[(w*4+l)*8 +: 8];
         rchk(req, 8'(8 + 4 * w), e);
      end
   endtask

   function automatic int idx_of(int seed, int i);
      if (seed == 0) return (i == 0) ? 0 : (i == 1) ? 510 : (i == 2) ? 255 : 1;
      return (seed * 131 + i * 97) % 511;
   endfunction

   function automatic int msk_of(int seed, int i);
      return (seed * 53 + i * 71 + 1) % 512;
   endfunction

   task automatic run_enc(input logic [NB*8-1:0] p, input logic [4:0] base, input bit rs);
      wr(8'h00, {27'd0, 1'b0, 1'b1, rs, 1'b1, 1'b1}, 4'h1);
      chk("R3 clear pulse", 32'(cdc_clear), 32'd1);
      chk("R4 no start while reset", 32'(cdc_start), 32'd0);
      @(negedge clk);
      chk("R3 clear one cycle", 32'(cdc_clear), 32'd0);
      chk("R4 start", 32'(cdc_start), 32'd1);
      chk("R4 encode kind", 32'(cdc_encode), 32'd1);
      chk("R2 rs mode out", 32'(cdc_rs), 32'(rs));
      @(negedge clk);
      chk("R4 start single", 32'(cdc_start), 32'd0);
      rchk("R3 reset bit self clears", 8'h00, {27'd0, 1'b0, 1'b1, rs, 1'b0, 1'b1});
      chk_par("R3 parity cleared", '0);
      @(negedge clk);
      cdc_enc_done = 1'b1; cdc_enc_par = p;
      @(negedge clk);
      cdc_enc_done = 1'b0;
      rchk("R4 enc finished flag", 8'h14, 32'(base | 5'h04));
      chk_par("R4 parity captured", p);
   endtask

   task automatic run_dec(input int cnt, input bit unc, input int seed, input logic [4:0] base);
      logic [NB*8-1:0] p;
      logic [4:0] ef;
      for (int k = 0; k < NB; k++) p[k*8 +: 8] = 8'((seed * 17 + k * 41 + 3) & 255);
      wr(8'h00, 32'h07, 4'h1);
      @(negedge clk);
      chk("R6 no start before parity", 32'(cdc_start), 32'd0);
      wr(8'h08, p[31:0], 4'hF);
      wr(8'h0C, p[63:32], 4'hF);
      wr(8'h10, {24'd0, p[71:64]}, 4'hF);
      chk("R6 no start without ready", 32'(cdc_start), 32'd0);
      wr(8'h00, 32'h15, 4'h1);
      chk("R6 start after ready", 32'(cdc_start), 32'd1);
      chk("R6 decode kind", 32'(cdc_encode), 32'd0);
      chk("R6 parity to codec lo", cdc_par_in[31:0], p[31:0]);
      chk("R6 parity to codec hi", {cdc_par_in[71:64], cdc_par_in[63:40]}, {p[71:64], p[63:40]});
      for (int i = 0; i < NE; i++) begin
         cdc_err_idx[i*SW +: SW] = SW'(idx_of(seed, i));
         cdc_err_msk[i*SW +: SW] = SW'(msk_of(seed, i));
      end
      @(negedge clk);
      cdc_dec_done = 1'b1; cdc_uncor = unc; cdc_err_cnt = CW'(cnt);
      @(negedge clk);
      cdc_dec_done = 1'b0; cdc_uncor = 1'b0;
      ef = base | 5'h08;
      if (unc) ef = ef | 5'h03;
      else if (cnt != 0) ef = ef | 5'h01;
      if (unc) rchk("R8 uncorrectable status", 8'h14, {3'd0, 24'd0, ef});
      else     rchk("R7 decode status", 8'h14, {3'(cnt), 24'd0, ef});
      for (int i = 0; i < NE; i++) begin
         logic [31:0] e;
         e = '0;
         if (!unc && i < cnt)
            e = (32'(idx_of(seed, i) + 1) << 16) | 32'(msk_of(seed, i));
         if (unc) rchk("R8 report words untouched", 8'(8'h1C + 4 * i), e);
         else     rchk("R7 report word", 8'(8'h1C + 4 * i), e);
      end
   endtask

   task automatic sweep_irq(input logic [4:0] pat);
      for (int m = 0; m < 32; m++) begin
         wr(8'h18, 32'(m), 4'h1);
         chk("R11 irq mask", 32'(irq), 32'((5'(m) & pat) != 0));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [NB*8-1:0] p;
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rchk("R1 ctl reset", 8'h00, 0);
      rchk("R1 status reset", 8'h14, 0);
      rchk("R1 ien reset", 8'h18, 0);
      for (int i = 0; i < NE; i++) rchk("R1 report reset", 8'(8'h1C + 4 * i), 0);
      chk("R1 irq reset", 32'(irq), 0);
      chk("R4 start reset", 32'(cdc_start), 0);

      // parity byte lanes
      p = '0;
      for (int k = 0; k < NB; k++) begin
         logic [7:0] b;
         b = 8'((k * 29 + 7) & 255);
         p[k*8 +: 8] = b;
         wr(8'(8 + 4 * (k / 4)), {4{b}}, 4'(1 << (k % 4)));
         chk_par("R5 byte lane write", p);
      end
      wr(8'h08, 32'hDEADBEEF, 4'h0);
      chk_par("R5 no lanes no write", p);
      chk("R5 codec parity view", cdc_par_in[71:40], p[71:40]);

      // control needs lane 0
      wr(8'h00, 32'h1F, 4'hE);
      rchk("R2 ctl ignored without lane0", 8'h00, 0);

      // encode
      run_enc(72'h0123456789ABCDEF55, 5'h00, 1'b1);
      wr(8'h14, 32'hFFFF_FFFF, 4'hF);
      rchk("R9 nonzero write ignored", 8'h14, 32'h04);
      wr(8'h14, 32'h0, 4'hF);
      rchk("R9 zero write clears", 8'h14, 32'h0);

      // completions outside their phase
      cdc_err_cnt = 3'd3;
      @(negedge clk); cdc_dec_done = 1'b1;
      @(negedge clk); cdc_dec_done = 1'b0;
      rchk("R13 stray decode done", 8'h14, 0);
      rchk("R13 stray decode words", 8'h1C, 0);
      @(negedge clk); cdc_enc_done = 1'b1; cdc_enc_par = '1;
      @(negedge clk); cdc_enc_done = 1'b0;
      rchk("R13 stray encode done", 8'h14, 0);
      chk_par("R13 parity kept", 72'h0123456789ABCDEF55);

      // encode without RS mode
      run_enc(72'hFEDCBA9876543210AA, 5'h00, 1'b0);
      wr(8'h14, 32'h0, 4'hF);

      // decode sweep
      run_dec(4, 1'b0, 0, 5'h00);
      for (int c = 0; c <= NE; c++) begin
         wr(8'h14, 32'h0, 4'hF);
         run_dec(c, 1'b0, c + 1, 5'h00);
      end
      wr(8'h14, 32'h0, 4'hF);
      run_dec(3, 1'b1, 7, 5'h00);

      // abort
      wr(8'h14, 32'h0, 4'hF);
      run_enc(72'h1111111111111111FF, 5'h00, 1'b1);
      wr(8'h00, 32'h07, 4'h1);
      wr(8'h00, 32'h15, 4'h1);
      @(negedge clk);
      wr(8'h00, 32'h00, 4'h1);
      chk("R10 abort pulse", 32'(cdc_abort), 1);
      @(negedge clk);
      chk("R10 abort one cycle", 32'(cdc_abort), 0);
      rchk("R10 status kept", 8'h14, 32'h04);
      cdc_err_cnt = 3'd2;
      @(negedge clk); cdc_dec_done = 1'b1;
      @(negedge clk); cdc_dec_done = 1'b0;
      rchk("R10 late done ignored", 8'h14, 32'h04);
      rchk("R10 late done no words", 8'h1C, 0);

      // padding and interrupt sweeps
      wr(8'h00, 32'h05, 4'h1);
      wr(8'h14, 32'h0, 4'hF);
      @(negedge clk); cdc_pad_done = 1'b1;
      @(negedge clk); cdc_pad_done = 1'b0;
      rchk("R12 pad flag", 8'h14, 32'h10);
      sweep_irq(5'h10);
      run_enc(72'h2222222222222222EE, 5'h10, 1'b1);
      sweep_irq(5'h14);
      run_dec(2, 1'b1, 9, 5'h14);
      sweep_irq(5'h1F);

      // data port
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hA5A5_0F0F; bus_be = 4'hF;
      #1;
      chk("R12 data valid", 32'(cdc_dat_vld), 1);
      chk("R12 data word", cdc_dat, 32'hA5A5_0F0F);
      bus_be = 4'h3;
      #1;
      chk("R12 partial data not valid", 32'(cdc_dat_vld), 0);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
      rchk("R1 data reads zero", 8'h04, 0);
      rchk("R1 unmapped reads zero", 8'h3C, 0);
      rd(8'h10, v);
      chk("R5 upper lanes zero", v[31:8], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule